// File: doc/BRIEF.md
# Minimum-flip coset codec

This block sits between a write-limited memory array and its user and encodes a 64-bit word so that rewriting a location changes as few stored cells as possible. The word is cut into sixteen 4-bit chunks. Each chunk is stored as an 8-bit vector taken from one coset of the self-dual length-8 first-order Reed-Muller code (the extended Hamming code with 8 bits and 4 data bits), so the stored line is twice as wide as the data. Every coset has sixteen members. On a write, the encoder is given the vector already held in the location. For each chunk it searches the sixteen members of the data's coset and keeps the one nearest to the old contents.

The caller may also supply a per-cell mask of known stuck cells and their stuck values. The search then considers only coset members that agree with those cells. If no member agrees, the chunk raises a fault bit and the unconstrained nearest member is written instead. The read path recovers each data bit as the XOR of a fixed subset of the stored bits.

Write and read are independent paths. Both are registered, so each output appears one clock after the inputs it depends on are sampled. The memory array itself is not part of the block.

Top module: `mfcoset_codec`

## Requirements
- R1: While rst_n is low, and at the first rising edge after it was low, new_vec, fault and rd_data are all zero.
- R2: new_vec, fault and rd_data are registered: each reflects the inputs sampled at the previous rising clock edge.
- R3: Chunk c occupies data bits [4c+3:4c] and vector bits [8c+7:8c]. Decoding a vector v gives data bit i as the XOR of v masked with 8'hFF for i=0, 8'h0F for i=1, 8'h33 for i=2 and 8'h55 for i=3. Decoding every chunk of new_vec returns the wr_data that produced it.
- R4: With a zero stuck mask for a chunk, the written chunk differs from prev_vec in the fewest bits of any vector that decodes to the chunk's data, and never in more than 2 bits.
- R5: Candidates are numbered j=0..15 as y XOR w_j. Here y is the XOR of 8'h80, 8'h88, 8'hA0 and 8'hC0, each included when data bit 0, 1, 2 or 3 respectively is set. w_j is the XOR of the four decode masks, with the mask for bit b included when bit b of j is set. Among candidates of least flip count, the lowest j is written.
- R6: With a nonzero stuck mask, if any candidate matches stuck_val on every masked cell, the written chunk is such a candidate with the fewest flips, lowest j first, and fault for that chunk is 0.
- R7: If no candidate matches the stuck cells, fault for that chunk is 1 and the chunk is the unconstrained choice of R4 and R5. fault is never 1 for a chunk whose stuck mask is zero.
- R8: rd_data holds the R3 decode of rd_vec, chunk by chunk.
- R9: Writing data that decodes from the old vector itself leaves the chunk unchanged (zero flips).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | 64 | Data word to encode |
| prev_vec | input | 128 | Vector currently held in the target location |
| stuck_mask | input | 128 | 1 marks a stuck cell |
| stuck_val | input | 128 | Value of each stuck cell |
| rd_vec | input | 128 | Stored vector to decode |
| new_vec | output | 128 | Encoded vector to write |
| fault | output | 16 | Per-chunk flag: stuck cells could not be honoured |
| rd_data | output | 64 | Decoded data word |

## Verification
Encoding and decoding run together every cycle, and the bench makes them meet on the same edge. It feeds each written vector back as the next cycle's prev_vec and also as rd_vec, so one clock both decodes the vector just written and encodes the next word against it. A behavioural model enumerates the sixteen candidates per chunk in the R5 numbering and predicts both outputs on every clock. That model is also used under stuck masks that can and cannot be satisfied. Separate checks cover the two-flip bound, unchanged rewrites, and a flip average close to 1.375 per chunk over a long random stream.

// File: rtl/mfcoset_codec.sv
module mfcoset_codec #(
  parameter int CHUNKS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CHUNKS*4-1:0]   wr_data,
  input  logic [CHUNKS*8-1:0]   prev_vec,
  input  logic [CHUNKS*8-1:0]   stuck_mask,
  input  logic [CHUNKS*8-1:0]   stuck_val,
  input  logic [CHUNKS*8-1:0]   rd_vec,
  output logic [CHUNKS*8-1:0]   new_vec,
  output logic [CHUNKS-1:0]     fault,
  output logic [CHUNKS*4-1:0]   rd_data
);
  localparam int DW = CHUNKS * 4;
  localparam int VW = CHUNKS * 8;

  function automatic logic [7:0] zero_member(input int j);
    logic [7:0] w;
    w = 8'h00;
    if (j[0]) w = w ^ 8'hFF;
    if (j[1]) w = w ^ 8'h0F;
    if (j[2]) w = w ^ 8'h33;
    if (j[3]) w = w ^ 8'h55;
    return w;
  endfunction

  function automatic logic [3:0] syndrome(input logic [7:0] v);
    return {^(v & 8'h55), ^(v & 8'h33), ^(v & 8'h0F), ^(v & 8'hFF)};
  endfunction

  logic [VW-1:0] enc_nxt;
  logic [CHUNKS-1:0] flt_nxt;
  logic [DW-1:0] dec_nxt;

  for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
    logic [3:0] d;
    logic [7:0] p, sm, sv, y, t, cand, pick_any, pick_ok;
    logic found;
    int w_any, w_ok, w;

    assign d  = wr_data[4*c +: 4];
    assign p  = prev_vec[8*c +: 8];
    assign sm = stuck_mask[8*c +: 8];
    assign sv = stuck_val[8*c +: 8];

    always_comb begin
      y = (d[0] ? 8'h80 : 8'h00) ^ (d[1] ? 8'h88 : 8'h00) ^
          (d[2] ? 8'hA0 : 8'h00) ^ (d[3] ? 8'hC0 : 8'h00);
      t = p ^ y;
      cand = t;
      pick_any = t;
      pick_ok = t;
      w_any = 9;
      w_ok = 9;
      w = 0;
      found = 1'b0;
      for (int j = 0; j < 16; j++) begin
        cand = t ^ zero_member(j);
        w = $countones(cand);
        if (w < w_any) begin
          w_any = w;
          pick_any = cand;
        end
        if ((((p ^ cand) ^ sv) & sm) == 8'h00 && w < w_ok) begin
          w_ok = w;
          pick_ok = cand;
          found = 1'b1;
        end
      end
    end

    assign enc_nxt[8*c +: 8] = p ^ (found ? pick_ok : pick_any);
    assign flt_nxt[c]        = ~found;
    assign dec_nxt[4*c +: 4] = syndrome(rd_vec[8*c +: 8]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_vec <= '0;
      fault   <= '0;
      rd_data <= '0;
    end else begin
      new_vec <= enc_nxt;
      fault   <= flt_nxt;
      rd_data <= dec_nxt;
    end
  end
endmodule

// File: rtl/mfcoset_codec_chk.sv
module mfcoset_codec_chk #(
  parameter int CHUNKS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CHUNKS*4-1:0] wr_data,
  input logic [CHUNKS*8-1:0] prev_vec,
  input logic [CHUNKS*8-1:0] stuck_mask,
  input logic [CHUNKS*8-1:0] stuck_val,
  input logic [CHUNKS*8-1:0] rd_vec,
  input logic [CHUNKS*8-1:0] new_vec,
  input logic [CHUNKS-1:0]   fault,
  input logic [CHUNKS*4-1:0] rd_data
);
  function automatic logic [3:0] dec8(input logic [7:0] v);
    return {^(v & 8'h55), ^(v & 8'h33), ^(v & 8'h0F), ^(v & 8'hFF)};
  endfunction

  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (new_vec == '0 && fault == '0 && rd_data == '0));

  for (genvar c = 0; c < CHUNKS; c++) begin : g_a
    a_r3_decodes_back: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> dec8(new_vec[8*c +: 8]) == $past(wr_data[4*c +: 4]));
    a_r4_two_flips: assert property (@(posedge clk) disable iff (!rst_n)
      live && $past(stuck_mask[8*c +: 8]) == 8'h00 |->
        $countones(new_vec[8*c +: 8] ^ $past(prev_vec[8*c +: 8])) <= 2);
    a_r6_stuck_kept: assert property (@(posedge clk) disable iff (!rst_n)
      live && !fault[c] |->
        ((new_vec[8*c +: 8] ^ $past(stuck_val[8*c +: 8])) & $past(stuck_mask[8*c +: 8])) == 8'h00);
    a_r7_fault_masked: assert property (@(posedge clk) disable iff (!rst_n)
      live && fault[c] |-> $past(stuck_mask[8*c +: 8]) != 8'h00);
    a_r8_read_path: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> rd_data[4*c +: 4] == dec8($past(rd_vec[8*c +: 8])));
  end
endmodule

bind mfcoset_codec mfcoset_codec_chk #(.CHUNKS(CHUNKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .prev_vec(prev_vec),
  .stuck_mask(stuck_mask), .stuck_val(stuck_val), .rd_vec(rd_vec),
  .new_vec(new_vec), .fault(fault), .rd_data(rd_data)
);

// File: tb/sim_mfcoset_codec.sv
module sim_mfcoset_codec;
  localparam int PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*4-1:0] wr_data = '0;
  logic [N*8-1:0] prev_vec = '0, stuck_mask = '0, stuck_val = '0, rd_vec = '0;
  logic [N*8-1:0] new_vec;
  logic [N-1:0]   fault;
  logic [N*4-1:0] rd_data;

  int checks = 0, errors = 0;
  logic [N*8-1:0] e_new = '0;
  logic [N-1:0]   e_flt = '0;
  logic [N*4-1:0] e_rd = '0;
  string tag = "R1";
  longint flip_sum = 0, flip_cnt = 0;

  always #(PERIOD/2) clk = ~clk;

  mfcoset_codec u0 (.clk(clk), .rst_n(rst_n), .wr_data(wr_data), .prev_vec(prev_vec),
    .stuck_mask(stuck_mask), .stuck_val(stuck_val), .rd_vec(rd_vec),
    .new_vec(new_vec), .fault(fault), .rd_data(rd_data));

  function automatic logic [3:0] decode(input logic [7:0] v);
    logic [7:0] m [4] = '{8'hFF, 8'h0F, 8'h33, 8'h55};
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = ^(v & m[i]);
    return r;
  endfunction

  // Candidate list per R5; picks per R4..R7.
  function automatic logic [8:0] model(input logic [3:0] d, input logic [7:0] p,
                                       input logic [7:0] sm, input logic [7:0] sv);
    logic [7:0] g [4] = '{8'h80, 8'h88, 8'hA0, 8'hC0};
    logic [7:0] m [4] = '{8'hFF, 8'h0F, 8'h33, 8'h55};
    logic [7:0] y = 8'h00, v, best_a = 8'h00, best_o = 8'h00;
    int wa = 99, wo = 99;
    for (int i = 0; i < 4; i++) if (d[i]) y ^= g[i];
    for (int j = 0; j < 16; j++) begin
      v = y;
      for (int b = 0; b < 4; b++) if (j[b]) v ^= m[b];
      if ($countones(v ^ p) < wa) begin wa = $countones(v ^ p); best_a = v; end
      if (((v ^ sv) & sm) == 8'h00 && $countones(v ^ p) < wo) begin
        wo = $countones(v ^ p); best_o = v;
      end
    end
    return (wo == 99) ? {1'b1, best_a} : {1'b0, best_o};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // At a falling edge: compare last prediction, then apply and predict new inputs.
  task automatic cyc(input logic rst, input logic [N*4-1:0] d, input logic [N*8-1:0] p,
                     input logic [N*8-1:0] sm, input logic [N*8-1:0] sv,
                     input logic [N*8-1:0] rv, input string t);
    logic [8:0] r;
    @(negedge clk);
    check({tag, " new_vec"}, 128'(new_vec), 128'(e_new));
    check({tag, " fault R7"}, 128'(fault), 128'(e_flt));
    check({tag, " rd_data R8"}, 128'(rd_data), 128'(e_rd));
    rst_n = rst; wr_data = d; prev_vec = p; stuck_mask = sm; stuck_val = sv; rd_vec = rv;
    tag = t;
    for (int c = 0; c < N; c++) begin
      r = model(d[4*c +: 4], p[8*c +: 8], sm[8*c +: 8], sv[8*c +: 8]);
      e_new[8*c +: 8] = rst ? r[7:0] : 8'h00;
      e_flt[c]        = rst ? r[8] : 1'b0;
      e_rd[4*c +: 4]  = rst ? decode(rv[8*c +: 8]) : 4'h0;
    end
  endtask

  function automatic logic [N*8-1:0] rnd_v();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction
  function automatic logic [N*4-1:0] rnd_d();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N*8-1:0] cur, sm, sv;
    logic [N*4-1:0] d;
    int mx;
    // R1: reset holds outputs at zero
    for (int i = 0; i < 3; i++) cyc(1'b0, rnd_d(), rnd_v(), '0, '0, rnd_v(), "R1");
    cur = '0;
    // R2 R4 R5 R8: write stream fed back as old contents and as read input
    for (int i = 0; i < 1500; i++) begin
      cyc(1'b1, rnd_d(), cur, '0, '0, cur, "R2 R4 R5");
      if (i > 0) begin
        @(posedge clk); #1;
        mx = 0;
        for (int c = 0; c < N; c++) begin
          mx = ($countones(new_vec[8*c +: 8] ^ cur[8*c +: 8]) > mx) ?
                $countones(new_vec[8*c +: 8] ^ cur[8*c +: 8]) : mx;
          flip_sum += $countones(new_vec[8*c +: 8] ^ cur[8*c +: 8]);
          flip_cnt++;
        end
        if (mx > 2) check("R4 flip bound", 128'(mx), 128'(2));
        cur = new_vec;
      end else begin
        @(posedge clk); #1; cur = new_vec;
      end
    end
    checks++;
    if (flip_sum * 1000 < flip_cnt * 1300 || flip_sum * 1000 > flip_cnt * 1450) begin
      errors++;
      $display("FAIL R4 average flips actual=%0d/%0d expected~1.375", flip_sum, flip_cnt);
    end
    // R3: arbitrary old contents
    for (int i = 0; i < 300; i++) cyc(1'b1, rnd_d(), rnd_v(), '0, '0, rnd_v(), "R3");
    // R9: rewrite data already held
    for (int i = 0; i < 40; i++) begin
      cur = rnd_v();
      for (int c = 0; c < N; c++) d[4*c +: 4] = decode(cur[8*c +: 8]);
      cyc(1'b1, d, cur, '0, '0, cur, "R9");
      @(posedge clk); #1;
      check("R9 unchanged", 128'(new_vec), 128'(cur));
    end
    // R6: one or two stuck cells per chunk, always satisfiable
    for (int i = 0; i < 300; i++) begin
      sm = '0;
      for (int c = 0; c < N; c++) begin
        sm[8*c + ($urandom % 8)] = 1'b1;
        if (i % 2 == 1) sm[8*c + ($urandom % 8)] = 1'b1;
      end
      cyc(1'b1, rnd_d(), rnd_v(), sm, rnd_v(), rnd_v(), "R6");
    end
    // R7: every cell stuck, mostly unsatisfiable
    for (int i = 0; i < 200; i++) begin
      sm = {N*8{1'b1}};
      sv = rnd_v();
      cyc(1'b1, rnd_d(), rnd_v(), sm, sv, rnd_v(), "R7");
    end
    // R1: reset again mid-run
    cyc(1'b0, rnd_d(), rnd_v(), '0, '0, rnd_v(), "R1");
    cyc(1'b0, rnd_d(), rnd_v(), '0, '0, rnd_v(), "R1");
    cyc(1'b1, '0, '0, '0, '0, '0, "R2");
    cyc(1'b1, '0, '0, '0, '0, '0, "R2");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule